// File: doc/BRIEF.md
# DMA Request Controller with Programmable Request and Terminal-Count Polarity

This block issues DMA requests for data moving between an external DMA engine and an on-chip RAM, and runs the acknowledge handshake for each transfer. Software sets up a RAM address pointer and a few control bits through a small register write port. Writing the low byte of the pointer arms the controller, provided the enable bit is set. From then on, each acknowledge pulse from the DMA engine completes one transfer and moves the pointer on.

The request output and the terminal-count input each have a configurable active level. When the terminal count is active during an acknowledged cycle, the transfer run ends and the request drops. The controller then sets a completion flag, which raises an interrupt if that interrupt is unmasked. The transfer width is not configured separately: it follows the shared 8/16-bit access setting, so the pointer steps by one byte or by one 16-bit word.

There are two modes. In single-transfer mode the request is withdrawn after every acknowledge and reasserted once the acknowledge is released. In demand mode the request is held across acknowledges until the terminal count.

Top module: `dmarq_ctrl`

## Requirements
- R1: After reset, dreq_o is low, irq_o and done_o are low, ram_addr_o is 0, the width is 8-bit, and both polarities are active-high.
- R2: Register selects are 0 = pointer low, 1 = pointer high, 2 = mask, 3 = bus control. Bits [2:0] of the pointer-high register are ram_addr_o[10:8], and its bit 3 is the enable. A write to pointer low loads ram_addr_o[7:0] and clears done_o. It asserts the request on the next cycle if the enable is 1, and withdraws it if the enable is 0.
- R3: Bus-control bit 2 set makes dreq_o active-low. When it is clear, dreq_o is active-high.
- R4: While the controller is armed, a high-to-low transition of dack_ni (sampled on the clock) completes one transfer. It adds 1 to ram_addr_o when bus-control bit 7 is 0 (8-bit) and 2 when that bit is 1 (16-bit). wide_o reflects bus-control bit 7.
- R5: tc_i is active-high when bus-control bit 3 is 0 and active-low when it is 1. If it is active at a completed transfer, the request drops and done_o sets. An inactive tc_i does neither.
- R6: irq_o equals done_o AND mask-register bit 4.
- R7: With bus-control bits [1:0] not equal to 01 (single-transfer), the request drops in the cycle after each completed transfer. It returns in the cycle after dack_ni is sampled high again.
- R8: With bus-control bits [1:0] = 01 (demand), the request stays asserted across completed transfers until the terminal count.
- R9: An acknowledge while the controller is not armed leaves ram_addr_o and done_o unchanged.
- R10: A pointer-low write in the same cycle as an acknowledge edge takes precedence. The pointer takes the written value and that acknowledge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| dack_ni | input | 1 | DMA acknowledge, active-low |
| tc_i | input | 1 | Terminal count, programmable polarity |
| dreq_o | output | 1 | DMA request, programmable polarity |
| irq_o | output | 1 | Completion interrupt |
| done_o | output | 1 | Completion status flag |
| wide_o | output | 1 | Shared 16-bit access setting |
| ram_addr_o | output | 11 | RAM address pointer |

## Verification
Two events can land on the same clock edge: an arming write to the pointer-low register and the falling edge of the acknowledge. The bench provokes this by driving the write strobe and pulling dack_ni low at the same falling clock edge. It then requires that the pointer shows exactly the written value, that the request stays asserted, and that holding the acknowledge low afterwards produces no late advance. The normal pairing of an acknowledge edge with an active terminal count is also exercised in both polarities.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_BUS    = 2'd3
  } reg_sel_e;

  localparam int EN_BIT       = 3;
  localparam int IRQ_EN_BIT   = 4;
  localparam int WIDE_BIT     = 7;
  localparam int DRQ_INV_BIT  = 2;
  localparam int TC_INV_BIT   = 3;
  localparam logic [1:0] MODE_DEMAND = 2'b01;

  typedef struct packed {
    logic       wide;
    logic       drq_inv;
    logic       tc_inv;
    logic [1:0] mode;
    logic       en;
    logic       irq_en;
  } cfg_t;
endpackage

// File: rtl/dmarq_cfg.sv
module dmarq_cfg
  import dmarq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output cfg_t          cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_i) begin
      unique case (reg_sel_e'(sel_i))
        SEL_PTR_HI: cfg_o.en <= wdata_i[EN_BIT];
        SEL_MASK:   cfg_o.irq_en <= wdata_i[IRQ_EN_BIT];
        SEL_BUS: begin
          cfg_o.wide    <= wdata_i[WIDE_BIT];
          cfg_o.drq_inv <= wdata_i[DRQ_INV_BIT];
          cfg_o.tc_inv  <= wdata_i[TC_INV_BIT];
          cfg_o.mode    <= wdata_i[1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dmarq_ptr.sv
module dmarq_ptr #(
  parameter int ADDR_W = 11,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              adv_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W = ADDR_W - DW;

  logic [ADDR_W-1:0] step, nxt;

  assign step = wide_i ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    nxt = ptr_o;
    if (load_lo_i) nxt[DW-1:0] = wdata_i;
    else if (adv_i) nxt = ptr_o + step;
    if (load_hi_i) nxt[ADDR_W-1:DW] = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= '0;
    else         ptr_o <= nxt;
  end

  // R4: one step per completed transfer
  p_adv_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_lo_i && !load_hi_i |=> ptr_o == $past(ptr_o) + (($past(wide_i)) ? ADDR_W'(2) : ADDR_W'(1)));
  // R10: a pointer-low write wins over an advance
  p_load_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_lo_i |=> ptr_o[DW-1:0] == $past(wdata_i));
endmodule

// File: rtl/dmarq_req.sv
module dmarq_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic en_i,
  input  logic demand_i,
  input  logic tc_act_i,
  input  logic dack_ni,
  output logic ack_evt_o,
  output logic req_act_o,
  output logic done_o
);
  logic dack_q, req_q, hold_q;

  // falling edge of acknowledge while armed; a same-cycle arm write discards it
  assign ack_evt_o = req_q & dack_q & ~dack_ni & ~arm_i;
  assign req_act_o = req_q & ~hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dack_q <= 1'b1;
      req_q  <= 1'b0;
      hold_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      dack_q <= dack_ni;
      if (arm_i) begin
        req_q  <= en_i;
        hold_q <= 1'b0;
        done_o <= 1'b0;
      end else if (ack_evt_o) begin
        if (tc_act_i) begin
          req_q  <= 1'b0;
          hold_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          hold_q <= ~demand_i;
        end
      end else if (hold_q && dack_ni) begin
        hold_q <= 1'b0;
      end
    end
  end

  p_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> req_act_o == $past(en_i) && !done_o);
  p_tc_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_evt_o && tc_act_i |=> !req_act_o && done_o);
  p_single_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_evt_o && !demand_i |=> !req_act_o);
  p_demand_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_evt_o && demand_i && !tc_act_i |=> req_act_o);
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && !arm_i |=> $stable(done_o));
endmodule

// File: rtl/dmarq_ctrl.sv
module dmarq_ctrl
  import dmarq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              dack_ni,
  input  logic              tc_i,
  output logic              dreq_o,
  output logic              irq_o,
  output logic              done_o,
  output logic              wide_o,
  output logic [ADDR_W-1:0] ram_addr_o
);
  cfg_t cfg;
  logic arm, load_hi, ack_evt, req_act, tc_act;

  assign arm     = reg_wr_i && reg_sel_i == SEL_PTR_LO;
  assign load_hi = reg_wr_i && reg_sel_i == SEL_PTR_HI;
  assign tc_act  = tc_i ^ cfg.tc_inv;

  dmarq_cfg #(.DW(DW)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .cfg_o(cfg)
  );

  dmarq_ptr #(.ADDR_W(ADDR_W), .DW(DW)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_lo_i(arm), .load_hi_i(load_hi),
    .wdata_i(reg_wdata_i), .adv_i(ack_evt), .wide_i(cfg.wide), .ptr_o(ram_addr_o)
  );

  dmarq_req u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .en_i(cfg.en),
    .demand_i(cfg.mode == MODE_DEMAND), .tc_act_i(tc_act), .dack_ni(dack_ni),
    .ack_evt_o(ack_evt), .req_act_o(req_act), .done_o(done_o)
  );

  assign dreq_o = req_act ^ cfg.drq_inv;
  assign irq_o  = done_o & cfg.irq_en;
  assign wide_o = cfg.wide;

  p_irq_needs_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
  p_idle_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_act && !reg_wr_i && $stable(dack_ni) |=> $stable(ram_addr_o));
endmodule

// File: tb/dmarq_ctrl_test.sv
module dmarq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic dack_n = 1'b1, tc = 1'b0;
  logic dreq, irq, done, wide;
  logic [10:0] addr;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dmarq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .dack_ni(dack_n), .tc_i(tc), .dreq_o(dreq),
    .irq_o(irq), .done_o(done), .wide_o(wide), .ram_addr_o(addr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ack_on(logic tcv);
    dack_n = 1'b0; tc = tcv;
    @(negedge clk);
  endtask

  task automatic ack_off();
    dack_n = 1'b1; tc = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 dreq", dreq, 0);
    check("R1 irq", irq, 0);
    check("R1 done", done, 0);
    check("R1 addr", addr, 0);
    check("R1 wide", wide, 0);
  endtask

  task automatic t_disabled();
    wreg(2'd1, 8'h00);
    wreg(2'd0, 8'h10);
    check("R2 no request when disabled", dreq, 0);
    ack_on(1'b1);
    check("R9 addr unchanged", addr, 11'h010);
    check("R9 done unchanged", done, 0);
    ack_off();
  endtask

  task automatic t_single8();
    wreg(2'd1, 8'h09);
    wreg(2'd0, 8'h20);
    check("R2 armed request", dreq, 1);
    check("R2 addr loaded", addr, 11'h120);
    ack_on(1'b0);
    check("R4 step 1", addr, 11'h121);
    check("R7 drop after ack", dreq, 0);
    ack_off();
    check("R7 reassert", dreq, 1);
    ack_on(1'b1);
    check("R5 final step", addr, 11'h122);
    check("R5 request ends", dreq, 0);
    check("R5 done set", done, 1);
    check("R6 masked", irq, 0);
    ack_off();
    wreg(2'd2, 8'h10);
    check("R6 irq unmasked", irq, 1);
    wreg(2'd0, 8'h00);
    check("R2 done cleared", done, 0);
    check("R6 irq follows done", irq, 0);
  endtask

  task automatic t_demand16();
    wreg(2'd3, 8'h81);
    check("R4 wide_o", wide, 1);
    wreg(2'd1, 8'h08);
    wreg(2'd0, 8'h00);
    ack_on(1'b0);
    check("R4 step 2", addr, 11'h002);
    check("R8 held", dreq, 1);
    ack_off();
    ack_on(1'b0);
    check("R4 step 2 again", addr, 11'h004);
    check("R8 still held", dreq, 1);
    ack_off();
    ack_on(1'b1);
    check("R5 end in demand", dreq, 0);
    check("R5 done demand", done, 1);
    check("R4 last addr", addr, 11'h006);
    ack_off();
  endtask

  task automatic t_polarity();
    wreg(2'd3, 8'h0C);
    check("R3 idle high when inverted", dreq, 1);
    wreg(2'd1, 8'h08);
    wreg(2'd0, 8'h30);
    check("R3 active low", dreq, 0);
    ack_on(1'b1);
    check("R5 inactive tc keeps run", done, 0);
    check("R7 dropped inverted", dreq, 1);
    ack_off();
    check("R7 reasserted inverted", dreq, 0);
    ack_on(1'b0);
    check("R5 active-low tc ends", done, 1);
    check("R5 request off inverted", dreq, 1);
    ack_off();
  endtask

  task automatic t_collide();
    wreg(2'd3, 8'h00);
    wreg(2'd1, 8'h08);
    wreg(2'd0, 8'h50);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h60; dack_n = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R10 write wins", addr, 11'h060);
    check("R10 still requesting", dreq, 1);
    @(negedge clk);
    check("R10 no late advance", addr, 11'h060);
    ack_off();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_single8();
    t_demand16();
    t_polarity();
    t_collide();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end
endmodule